// File: doc/BRIEF.md
# Programmable CRC Engine

The block keeps a running cyclic redundancy checksum over 32-bit words that a host writes through a small register bus. Each word written to the data register is folded into the checksum in a single clock cycle, and the result is read back from the same address. A control register picks one of four polynomial degrees (32, 16, 8 or 7 bits). It also chooses how the bits of each incoming word are mirrored and whether the checksum is mirrored on read-back.

The host first programs the seed register and the polynomial register. It then writes the control register with its self-clearing restart bit set, which reloads the checksum from the seed. The host then streams data words, one per cycle if it wants. The polynomial register holds only the low-order coefficients, and the leading term is implied by the chosen degree. For degrees below 32 the checksum lives in the low bits of the data register.

Top module: `crc_unit`

## Requirements
- R1: After reset the control register reads 0x00000000, the seed register (offset 0x10) reads 0xFFFFFFFF, the polynomial register (offset 0x14) reads 0x04C11DB7 and the data register (offset 0x00) reads 0xFFFFFFFF.
- R2: Writing the control register (offset 0x08) with bit 0 set loads the checksum with the seed, masked to the selected degree. Bit 0 reads 1 in the cycle after that write and 0 afterwards, and writing 0 to it has no effect.
- R3: Control bits 31:8 and 2:1 always read as zero, whatever was written to them.
- R4: Control bits 6:5 mirror each data word before use: 00 leaves it as is, 01 mirrors the bits inside each byte, 10 mirrors them inside each 16-bit half, and 11 mirrors all 32 bits.
- R5: Control bits 4:3 select the degree: 00 gives 32, 01 gives 16, 10 gives 8 and 11 gives 7. The checksum bits above the degree read as zero.
- R6: With control bit 7 set, a read of the data register returns the low N checksum bits in mirrored order. With bit 7 clear, the checksum is returned unchanged.
- R7: Each data write advances the checksum by the 32 input bits, most significant bit first, in one cycle. Back-to-back writes are each applied, and the checksum holds when no data or control write occurs.
- R8: Only the low N bits of the polynomial register are used, with the x^N term implied. A non-default polynomial changes the result as the bit-serial definition predicts.
- R9: A data write in the cycle right after a restart (while bit 0 still reads 1) is applied on top of the freshly loaded seed.
- R10: The seed and polynomial registers read back the full 32-bit value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register at `addr` (combinational) |

## Verification
The update is run for every pairing of the four degrees with the four input mirror modes and both output settings. Varied seeds and data words are used so that a wrong mirror granularity or a wrong feedback tap gives a different value. The nine-character digit string is fed with a precomputed equivalent seed, in plain form and in fully reflected form. This separates a correct word-level bit order from a byte-swapped one and matches the two well-known 32-bit check values. Directed runs use a custom polynomial, back-to-back words, a data write straight after a restart, and a change of degree. These show that the mask, the implied leading term and the ordering of seed load against data fold are handled correctly.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int WORD_W = 32;
  localparam int NUM_WIDTHS = 4;

  localparam logic [7:0] OFF_DATA = 8'h00;
  localparam logic [7:0] OFF_CTRL = 8'h08;
  localparam logic [7:0] OFF_SEED = 8'h10;
  localparam logic [7:0] OFF_POLY = 8'h14;

  localparam logic [WORD_W-1:0] SEED_RST = 32'hFFFF_FFFF;
  localparam logic [WORD_W-1:0] POLY_RST = 32'h04C1_1DB7;

  typedef enum logic [1:0] {PW_32 = 2'd0, PW_16 = 2'd1, PW_8 = 2'd2, PW_7 = 2'd3} poly_w_e;
  typedef enum logic [1:0] {MIR_NONE = 2'd0, MIR_BYTE = 2'd1, MIR_HALF = 2'd2, MIR_WORD = 2'd3} mir_e;

  typedef struct packed {
    logic    mir_out;
    mir_e    mir_in;
    poly_w_e pw;
  } ctrl_t;

  // Degree for a width code; the code doubles as the lane index.
  function automatic int degree_of(input int code);
    case (code)
      0:       return 32;
      1:       return 16;
      2:       return 8;
      default: return 7;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] mask_of(input poly_w_e pw);
    case (pw)
      PW_32:   return 32'hFFFF_FFFF;
      PW_16:   return 32'h0000_FFFF;
      PW_8:    return 32'h0000_00FF;
      default: return 32'h0000_007F;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_view(input ctrl_t c, input logic flag);
    return {24'd0, c.mir_out, c.mir_in, c.pw, 2'b00, flag};
  endfunction
endpackage

// File: rtl/crc_in_mirror.sv
module crc_in_mirror
  import crc_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  mir_e              mode_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] by_byte, by_half, by_word;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign by_byte[i] = word_i[(i & ~7)  + 7  - (i & 7)];
    assign by_half[i] = word_i[(i & ~15) + 15 - (i & 15)];
    assign by_word[i] = word_i[WORD_W - 1 - i];
  end

  always_comb begin
    case (mode_i)
      MIR_BYTE: word_o = by_byte;
      MIR_HALF: word_o = by_half;
      MIR_WORD: word_o = by_word;
      default:  word_o = word_i;
    endcase
  end
endmodule

// File: rtl/crc_lane.sv
module crc_lane
  import crc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]      crc_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [W-1:0]      poly_i,
  output logic [W-1:0]      crc_o
);
  logic [W-1:0] st;
  logic         fb;

  // Thirty-two shift steps, unrolled into one cycle of logic.
  always_comb begin
    st = crc_i;
    fb = 1'b0;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      fb = st[W-1] ^ word_i[b];
      st = {st[W-2:0], 1'b0};
      if (fb) st = st ^ poly_i;
    end
    crc_o = st;
  end
endmodule

// File: rtl/crc_out_mirror.sv
module crc_out_mirror
  import crc_pkg::*;
(
  input  logic [WORD_W-1:0] crc_i,
  input  poly_w_e           pw_i,
  input  logic              en_i,
  output logic [WORD_W-1:0] crc_o
);
  logic [WORD_W-1:0] flip [NUM_WIDTHS];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_w
    localparam int W = degree_of(g);
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      if (i < W) begin : g_in
        assign flip[g][i] = crc_i[W-1-i];
      end else begin : g_out
        assign flip[g][i] = 1'b0;
      end
    end
  end

  assign crc_o = en_i ? flip[pw_i] : crc_i;
endmodule

// File: rtl/crc_unit.sv
module crc_unit
  import crc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam logic [ADDR_W-1:0] A_DATA = OFF_DATA[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CTRL = OFF_CTRL[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_SEED = OFF_SEED[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_POLY = OFF_POLY[ADDR_W-1:0];

  ctrl_t             ctrl_q, ctrl_new;
  logic              rst_flag;
  logic [WORD_W-1:0] init_q, poly_q, crc_q;

  // Named events for the checker.
  logic data_wr, ctrl_wr, seed_load;
  logic [WORD_W-1:0] cur_mask, new_mask;

  assign data_wr   = wr_en && (addr == A_DATA);
  assign ctrl_wr   = wr_en && (addr == A_CTRL);
  assign seed_load = ctrl_wr && wdata[0];
  assign ctrl_new  = ctrl_t'(wdata[7:3]);
  assign cur_mask  = mask_of(ctrl_q.pw);
  assign new_mask  = mask_of(ctrl_new.pw);

  logic [WORD_W-1:0] din_m, crc_next, crc_rd;
  logic [WORD_W-1:0] lane_out [NUM_WIDTHS];

  crc_in_mirror u_in (
    .word_i (wdata),
    .mode_i (ctrl_q.mir_in),
    .word_o (din_m)
  );

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_lane
    localparam int W = degree_of(g);
    logic [W-1:0] nxt;
    crc_lane #(.W(W)) u_lane (
      .crc_i  (crc_q[W-1:0]),
      .word_i (din_m),
      .poly_i (poly_q[W-1:0]),
      .crc_o  (nxt)
    );
    assign lane_out[g] = WORD_W'(nxt);
  end

  assign crc_next = lane_out[ctrl_q.pw];

  crc_out_mirror u_out (
    .crc_i (crc_q),
    .pw_i  (ctrl_q.pw),
    .en_i  (ctrl_q.mir_out),
    .crc_o (crc_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      rst_flag <= 1'b0;
      init_q   <= SEED_RST;
      poly_q   <= POLY_RST;
      crc_q    <= SEED_RST;
    end else begin
      rst_flag <= seed_load;
      if (ctrl_wr) ctrl_q <= ctrl_new;
      if (wr_en && addr == A_SEED) init_q <= wdata;
      if (wr_en && addr == A_POLY) poly_q <= wdata;
      if (seed_load)    crc_q <= init_q & new_mask;
      else if (ctrl_wr) crc_q <= crc_q & new_mask;
      else if (data_wr) crc_q <= crc_next;
    end
  end

  always_comb begin
    case (addr)
      A_DATA:  rdata = crc_rd;
      A_CTRL:  rdata = ctrl_view(ctrl_q, rst_flag);
      A_SEED:  rdata = init_q;
      A_POLY:  rdata = poly_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/crc_unit_chk.sv
module crc_unit_chk
  import crc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seed_load,
  input logic              data_wr,
  input logic              ctrl_wr,
  input logic              rst_flag,
  input logic              mir_out,
  input logic [WORD_W-1:0] crc_q,
  input logic [WORD_W-1:0] init_q,
  input logic [WORD_W-1:0] cur_mask,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata
);
  p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (crc_q == ($past(init_q) & cur_mask)));

  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> rst_flag);

  p_flag_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_load |=> !rst_flag);

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFF_CTRL[ADDR_W-1:0]) |-> (rdata[31:8] == '0 && rdata[2:1] == 2'b00));

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_q & ~cur_mask) == '0);

  p_plain_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFF_DATA[ADDR_W-1:0] && !mir_out) |-> (rdata == crc_q));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_wr && !ctrl_wr) |=> $stable(crc_q));
endmodule

bind crc_unit crc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .seed_load (seed_load),
  .data_wr   (data_wr),
  .ctrl_wr   (ctrl_wr),
  .rst_flag  (rst_flag),
  .mir_out   (ctrl_q.mir_out),
  .crc_q     (crc_q),
  .init_q    (init_q),
  .cur_mask  (cur_mask),
  .addr      (addr),
  .rdata     (rdata)
);

// File: tb/crc_unit_tb.sv
module crc_unit_tb_top;
  localparam int AW = 5;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crc_unit #(.ADDR_W(AW)) dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  localparam logic [31:0] WORDS [8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
    32'h8000_0001, 32'hA5C3_0F96, 32'h0102_0408, 32'hDEAD_BEEF, 32'h7F00_FF80};
  localparam logic [31:0] SEEDS [4] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h5A5A_1234, 32'hC001_D00D};

  function automatic int deg(input int pw);
    return (pw == 0) ? 32 : (pw == 1) ? 16 : (pw == 2) ? 8 : 7;
  endfunction
  function automatic logic [31:0] msk(input int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction
  // Mirror within groups of g bits.
  function automatic logic [31:0] mir(input logic [31:0] x, input int g);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) r[(b / g) * g + (g - 1 - b % g)] = x[b];
    return r;
  endfunction
  function automatic logic [31:0] mir_n(input logic [31:0] x, input int n);
    logic [31:0] r = '0;
    for (int b = 0; b < n; b++) r[n - 1 - b] = x[b];
    return r;
  endfunction
  // Bit-serial model: inject the bit at the top, shift, reduce by the full polynomial.
  function automatic logic [31:0] model(input logic [31:0] s, input logic [31:0] d,
                                        input int n, input logic [31:0] p);
    logic [32:0] t = {1'b0, s & msk(n)};
    logic [32:0] full = ({1'b0, p & msk(n)}) | (33'd1 << n);
    for (int b = 31; b >= 0; b--) begin
      t = t ^ ({32'd0, d[b]} << (n - 1));
      t = t << 1;
      if (t[n]) t = t ^ full;
    end
    return t[31:0] & msk(n);
  endfunction
  function automatic logic [31:0] in_mode(input logic [31:0] d, input int m);
    return (m == 0) ? d : (m == 1) ? mir(d, 8) : (m == 2) ? mir(d, 16) : mir(d, 32);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask
  // Called at a falling edge; returns at the next falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a[AW-1:0]; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a[AW-1:0];
    #1 d = rdata;
  endtask
  function automatic logic [31:0] cw(input int rout, input int rin, input int pw, input bit go);
    return {24'd0, rout[0], rin[1:0], pw[1:0], 2'b00, go};
  endfunction

  initial begin
    logic [31:0] v, exp, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h08, v); check("R1 ctrl", v, 32'h0);
    rd(8'h10, v); check("R1 seed", v, 32'hFFFF_FFFF);
    rd(8'h14, v); check("R1 poly", v, 32'h04C1_1DB7);
    rd(8'h00, v); check("R1 data", v, 32'hFFFF_FFFF);

    // Table walk: all degrees x input modes x output mirror (R4 R5 R6 R7).
    for (int c = 0; c < 32; c++) begin
      int pw = c / 8, rin = c % 4, rout = (c / 4) % 2, n = deg(c / 8);
      logic [31:0] sd = SEEDS[c % 4], w0 = WORDS[c % 8], w1 = WORDS[(c + 3) % 8];
      wr(8'h10, sd);
      wr(8'h08, cw(rout, rin, pw, 1'b1));
      wr(8'h00, w0);
      wr(8'h00, w1);
      exp = model(model(sd & msk(n), in_mode(w0, rin), n, 32'h04C1_1DB7), in_mode(w1, rin), n, 32'h04C1_1DB7);
      if (rout != 0) exp = mir_n(exp, n);
      rd(8'h00, v);
      check($sformatf("R4 R5 R6 combo %0d", c), v, exp);
    end

    // Digit string: three leading zero bytes with an equivalent seed (R7).
    s = 32'hFFFF_FFFF;
    for (int k = 0; k < 24; k++) s = s[0] ? (((s ^ 32'h04C1_1DB7) >> 1) | 32'h8000_0000) : (s >> 1);
    wr(8'h10, s);
    wr(8'h08, cw(0, 0, 0, 1'b1));
    wr(8'h00, 32'h0000_0031); wr(8'h00, 32'h3233_3435); wr(8'h00, 32'h3637_3839);
    rd(8'h00, v); check("R7 plain check value", v, 32'h0376_E6E7);
    wr(8'h08, cw(1, 1, 0, 1'b1));
    wr(8'h00, 32'h0000_0031); wr(8'h00, 32'h3233_3435); wr(8'h00, 32'h3637_3839);
    rd(8'h00, v); check("R7 reflected check value", v, 32'h340B_C6D9);

    // R2 / R9: flag pulse, and a data write in the flagged cycle.
    wr(8'h10, 32'h0BAD_F00D); rd(8'h10, v); check("R10 seed readback", v, 32'h0BAD_F00D);
    wr(8'h08, cw(0, 0, 1, 1'b1));
    rd(8'h08, v); check("R2 flag high", v, cw(0, 0, 1, 1'b1));
    rd(8'h00, v); check("R2 seed masked", v, 32'h0000_F00D);
    wr(8'h00, 32'hCAFE_0001);
    rd(8'h08, v); check("R2 flag cleared", v, cw(0, 0, 1, 1'b0));
    rd(8'h00, v); check("R9 write after restart", v, model(32'hF00D, 32'hCAFE_0001, 16, 32'h04C1_1DB7));
    exp = v;
    wr(8'h08, cw(0, 0, 1, 1'b0));
    rd(8'h00, v); check("R2 zero write no reload", v, exp);
    repeat (3) @(negedge clk);
    rd(8'h00, v); check("R7 holds when idle", v, exp);

    // R3 reserved bits.
    wr(8'h08, 32'hFFFF_FF06);
    rd(8'h08, v); check("R3 reserved zero", v, 32'h0000_0000);

    // R8 custom polynomial at 8 bits, upper register bits ignored.
    wr(8'h14, 32'hABCD_EF07); rd(8'h14, v); check("R10 poly readback", v, 32'hABCD_EF07);
    wr(8'h10, 32'h0000_00A5);
    wr(8'h08, cw(0, 0, 2, 1'b1));
    wr(8'h00, 32'h1357_9BDF);
    rd(8'h00, v); check("R8 custom poly", v, model(32'hA5, 32'h1357_9BDF, 8, 32'h07));
    // R7 back-to-back words held on the bus across two edges.
    wr_en = 1'b1; addr = '0; wdata = 32'h1111_2222;
    @(negedge clk); wdata = 32'h3333_4444;
    @(negedge clk); wr_en = 1'b0;
    exp = model(model(model(32'hA5, 32'h1357_9BDF, 8, 32'h07), 32'h1111_2222, 8, 32'h07), 32'h3333_4444, 8, 32'h07);
    rd(8'h00, v); check("R7 back-to-back", v, exp);
    // R5 shrinking degree keeps upper bits clear; 7-bit with mirrored read.
    wr(8'h08, cw(1, 0, 3, 1'b0));
    rd(8'h00, v); check("R5 R6 7-bit view", v, mir_n(exp & 32'h7F, 7));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule